// File: doc/BRIEF.md
# MSB-First Even-Parity Serial Transmitter

This block turns one data byte into a framed serial stream on a single output line. A one-cycle enable strobe copies the byte into an internal shift register. The block then sends a low start bit, the eight data bits beginning with the most significant one, a parity bit that makes the frame even parity, and a high stop bit.

Bit timing comes entirely from an outside baud tick. The tick is a one-cycle pulse, one per bit period. The line changes only on the clock edge that closes a tick cycle. While a frame is in progress, a busy output stays high and further enable strobes are ignored.

Top module: `msbParityTx`

## Requirements
- R1: After the synchronous reset, and whenever the block is not busy, `txLine` is 1 and `txBusy` is 0.
- R2: An enable strobe while not busy is accepted: `txBusy` is 1 from the next cycle, and `txLine` stays 1 until the next baud tick.
- R3: On the successive baud ticks after acceptance, `txLine` takes these values in order: 0 (start), data bit 7, bit 6, and so on down to bit 0, then the parity bit, then 1 (stop). Each value appears in the cycle after its tick.
- R4: The parity bit equals the XOR of the eight data bits, so the data and parity bits together hold an even number of ones.
- R5: `txLine` changes value only in a cycle that directly follows a cycle with `baudTick` high.
- R6: The byte is captured in the enable cycle, and changes on `txData` after that do not alter the frame being sent.
- R7: An enable strobe that arrives while `txBusy` is 1 has no effect: the current frame continues unchanged and no extra frame follows it.
- R8: The stop bit is held for one full tick interval. `txBusy` falls in the cycle after the tick that ends the stop bit, with `txLine` at 1, and an enable in that next cycle starts a new frame.
- R9: A baud tick in the same cycle as an accepted enable does not count as a bit boundary. The start bit goes out on the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txData | input | 8 | Byte to send, sampled at the enable strobe |
| txEn | input | 1 | One-cycle start strobe |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| txLine | output | 1 | Serial output line, idles high |
| txBusy | output | 1 | High while a frame is pending or being sent |

## Verification
The bench goes after several corner cases, each with a known failure symptom:
- **Ticks back to back.** A tick arrives on every cycle. A design that miscounts bit positions would drop a data bit or stretch the stop bit.
- **Tick in the enable cycle.** A tick lands in the same cycle as the enable. A design that treats it as a boundary would send a start bit that is too short.
- **Data input changes mid-frame.** The byte input is inverted right after the enable. A design that reads the input live would send the inverted bits.
- **Enable while busy.** Enable pulses arrive during a frame. A design that accepts them would restart the frame or queue a second one.
- **Back-to-back frames.** A new frame starts right after busy falls. A design that leaves idle late would miss that enable, and one that leaves early would cut the stop bit short.

Several bytes are sent to cover the parity and ordering rules. 0xA5, 0x01, 0x80 and 0xFF catch a design that sends LSB first or computes odd parity, since either one changes the captured bit sequence.

// File: rtl/msbTxPkg.sv
package msbTxPkg;
  // Strobes issued by the sequencer to the bit datapath
  typedef struct packed {
    logic capture;     // copy byte into shift register, compute parity
    logic sendStart;   // drive start bit (0)
    logic sendData;    // drive current MSB, shift left
    logic sendParity;  // drive parity bit
    logic sendStop;    // drive stop bit (1)
  } txStrobes_t;
endpackage

// File: rtl/txControl.sv
module txControl
  import msbTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txEn,
  input  logic       baudTick,
  output txStrobes_t strobes,
  output logic       busy
);
  // positions: 0 start, 1..DATA_W data, DATA_W+1 parity, DATA_W+2 stop
  localparam int LAST_POS = DATA_W + 2;
  localparam int POS_W    = $clog2(LAST_POS + 1);

  typedef enum logic [1:0] {IDLE, ARMED, FRAME} state_t;

  state_t           state, stateNext;
  logic [POS_W-1:0] bitPos, bitPosNext;

  always_comb begin
    stateNext  = state;
    bitPosNext = bitPos;
    strobes    = '0;
    unique case (state)
      IDLE: begin
        if (txEn) begin
          strobes.capture = 1'b1;
          stateNext       = ARMED;
        end
      end
      ARMED: begin
        if (baudTick) begin
          strobes.sendStart = 1'b1;
          bitPosNext        = '0;
          stateNext         = FRAME;
        end
      end
      FRAME: begin
        if (baudTick) begin
          if (bitPos == POS_W'(LAST_POS)) begin
            stateNext = IDLE;
          end else begin
            bitPosNext = bitPos + 1'b1;
            if (bitPos < POS_W'(DATA_W))
              strobes.sendData = 1'b1;
            else if (bitPos == POS_W'(DATA_W))
              strobes.sendParity = 1'b1;
            else
              strobes.sendStop = 1'b1;
          end
        end
      end
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= IDLE;
      bitPos <= '0;
    end else begin
      state  <= stateNext;
      bitPos <= bitPosNext;
    end
  end

  assign busy = (state != IDLE);
endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import msbTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] txData,
  output logic              txLine
);
  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic              lineReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      lineReg   <= 1'b1;
    end else begin
      if (strobes.capture) begin
        shiftReg  <= txData;
        parityBit <= ^txData;
      end else if (strobes.sendData) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end

      if (strobes.sendStart)
        lineReg <= 1'b0;
      else if (strobes.sendData)
        lineReg <= shiftReg[DATA_W-1];
      else if (strobes.sendParity)
        lineReg <= parityBit;
      else if (strobes.sendStop)
        lineReg <= 1'b1;
    end
  end

  assign txLine = lineReg;
endmodule

// File: rtl/msbParityTx.sv
module msbParityTx
  import msbTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEn,
  input  logic              baudTick,
  output logic              txLine,
  output logic              txBusy
);
  txStrobes_t strobes;

  txControl #(.DATA_W(DATA_W)) ctrl (
    .clk      (clk),
    .rst      (rst),
    .txEn     (txEn),
    .baudTick (baudTick),
    .strobes  (strobes),
    .busy     (txBusy)
  );

  txDatapath #(.DATA_W(DATA_W)) dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .txData  (txData),
    .txLine  (txLine)
  );
endmodule

// File: rtl/msbParityTxChecker.sv
module msbParityTxChecker (
  input logic clk,
  input logic rst,
  input logic txEn,
  input logic baudTick,
  input logic txLine,
  input logic txBusy
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !txBusy |-> txLine);

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(txBusy) |-> ($past(txEn) && txLine));

  assert_tick_edges_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(txLine) |-> $past(baudTick));

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (txBusy && txEn && !baudTick) |=> txBusy);

  assert_stop_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(txBusy) |-> ($past(baudTick) && txLine));
endmodule

bind msbParityTx msbParityTxChecker chk (
  .clk      (clk),
  .rst      (rst),
  .txEn     (txEn),
  .baudTick (baudTick),
  .txLine   (txLine),
  .txBusy   (txBusy)
);

// File: tb/msbParityTx_test.sv
`timescale 1ns/1ps
module msbParityTx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] txData = 8'h00;
  logic       txEn = 1'b0;
  logic       baudTick = 1'b0;
  logic       txLine;
  logic       txBusy;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    cycles = 0;
  bit    cmpOn = 1'b0;
  string curTag = "R1";

  // reference model state
  bit mBusy = 1'b0;
  bit mLine = 1'b1;
  bit mQ[$];

  always #2.5 clk = ~clk;

  msbParityTx uut (
    .clk(clk), .rst(rst), .txData(txData), .txEn(txEn),
    .baudTick(baudTick), .txLine(txLine), .txBusy(txBusy)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // behavioural model, updated at each rising edge from the inputs
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mBusy = 1'b0;
      mLine = 1'b1;
      mQ.delete();
    end else if (!mBusy) begin
      if (txEn) begin
        mBusy = 1'b1;
        mQ.push_back(1'b0);
        for (int i = 7; i >= 0; i--) mQ.push_back(txData[i]);
        mQ.push_back(^txData);
        mQ.push_back(1'b1);
      end
    end else if (baudTick) begin
      if (mQ.size() > 0) mLine = mQ.pop_front();
      else mBusy = 1'b0;
    end
  end

  // compare against model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      check({curTag, " model line (R5)"}, txLine, mLine);
      check({curTag, " model busy"}, txBusy, mBusy);
    end
    if (cycles > 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  // send one frame; gap = cycles between ticks
  task automatic sendFrame(input logic [7:0] d, input int gap,
                           input bit flipData, input bit pokeEn, input bit coTick);
    bit seen[11];
    bit exp[11];
    exp[0] = 1'b0;
    for (int i = 0; i < 8; i++) exp[i+1] = d[7-i];
    exp[9]  = ^d;
    exp[10] = 1'b1;

    curTag = "R2";
    check("R2 idle before enable", txBusy, 1'b0);
    txData = d;
    txEn = 1'b1;
    if (coTick) baudTick = 1'b1;
    @(negedge clk);
    txEn = 1'b0;
    baudTick = 1'b0;
    if (flipData) txData = ~d;
    check("R2 busy after enable", txBusy, 1'b1);
    check(coTick ? "R9 line high after co-tick" : "R2 line high before tick", txLine, 1'b1);
    curTag = "R3";
    for (int b = 0; b < 11; b++) begin
      for (int g = 0; g < gap - 1; g++) begin
        if (pokeEn && g == 0) txEn = 1'b1;
        if (pokeEn && g == 0 && flipData) txData = 8'h3C;
        @(negedge clk);
        txEn = 1'b0;
      end
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
      seen[b] = txLine;
    end
    for (int b = 0; b < 11; b++) begin
      if (b == 9) check("R4 parity bit", seen[b], exp[b]);
      else check($sformatf("R3 frame bit %0d (R6 R7)", b), seen[b], exp[b]);
    end
    curTag = "R8";
    for (int g = 0; g < gap - 1; g++) @(negedge clk);
    check("R8 busy during stop", txBusy, 1'b1);
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    check("R8 busy fell after stop", txBusy, 1'b0);
    check("R8 line high after stop", txLine, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmpOn = 1'b1;
    check("R1 reset line", txLine, 1'b1);
    check("R1 reset busy", txBusy, 1'b0);
    repeat (4) @(negedge clk);
    // R1: ticks while idle do not move the line
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
    check("R1 idle tick ignored", txLine, 1'b1);

    sendFrame(8'hA5, 4, 1'b0, 1'b0, 1'b0);
    sendFrame(8'h01, 1, 1'b0, 1'b0, 1'b0);   // ticks back to back, R8 back-to-back start
    sendFrame(8'h80, 3, 1'b1, 1'b0, 1'b0);   // R6 data changes after capture
    sendFrame(8'hFF, 5, 1'b1, 1'b1, 1'b0);   // R7 enable while busy
    sendFrame(8'h6E, 4, 1'b0, 1'b0, 1'b1);   // R9 tick coincides with enable
    sendFrame(8'h00, 2, 1'b0, 1'b1, 1'b0);

    curTag = "R7";
    repeat (12) @(negedge clk);
    check("R7 no extra frame", txBusy, 1'b0);
    finishRun();
  end
endmodule